// File: doc/BRIEF.md
# Buffered Bulk-Programming Write Controller

This block drives the data phase of a bulk factory-programming mode for a flash array. Once the surrounding command logic arms it, the host sends 16-bit words with a word address. The block collects them into a 32-entry staging buffer. When the last slot is written, the block copies the whole buffer into the array through a simple write port. The port commits one word every four clock cycles, and each word goes to the next array address in turn. The array pointer keeps running from one buffer to the next, so a block can be filled by repeating fill and transfer until the host leaves.

The host watches an 8-bit status word:
- Bit 0 shows that a transfer is in progress.
- Bit 4 reports an aborted fill.
- Bit 7 shows that the block is back in its normal, ready state.

The block latches the 64K-word block that the host is writing from address bits [22:16] of the first word it takes. Any later word that names another block is the exit command. The host writes 0xFFFF as data by convention, but the data value is not checked. If that word arrives part-way through a fill, the loaded words are discarded without being programmed.

The host write channel uses valid/ready. `wr_ready` is held high in every state, so the block never stalls the host. A word is taken on any clock edge where `wr_valid` is high. Words taken while the block is ready or transferring are consumed and have no effect. A host that needs to pace itself must poll status bit 0.

Top module: `bfp_wctl`

## Requirements
- R1: After reset, and after an exit or abort, status reads 0x80 (bit 7 ready) and `arr_we` is low. A one-cycle `arm` pulse while ready sets status to 0x00 and clears the error bit.
- R2: Accepted words fill buffer slots 0 to 31 in arrival order. Taking the 32nd word sets status bit 0 (status 0x01) in the following cycle.
- R3: The array port commits the slots in order, slot 0 first, with one `arr_we` pulse per word. If the edge that takes the 32nd word is cycle 0, the first pulse is high during cycle 3 (it commits at the edge ending cycle 3). Later pulses follow exactly every 4 cycles.
- R4: The first buffer of a mode goes to the array starting at the address of the mode's first accepted word. Each later buffer continues at the word after the previous buffer's last word, whatever host addresses the later fill uses. A new `arm` restarts the pointer.
- R5: Status bit 0 stays set for exactly 128 cycles after the 32nd word is taken. It then clears (status 0x00), and the next fill is accepted.
- R6: Words offered while bit 0 is set are ignored, including words that name another block. The mode stays active and later buffer contents are unaffected.
- R7: If the first word of a fill has a nonzero address[4:0], the fill aborts. Status becomes 0x90 (ready plus error) and nothing is programmed. The block check is applied before the alignment check.
- R8: Between fills, a word whose address[22:16] differs from the latched block ends the mode. Status becomes 0x80.
- R9: A word naming another block during a partly loaded fill ends the mode at once. Status becomes 0x80 with no error, and no word of that fill ever reaches the array.
- R10: `wr_ready` is always high. Words offered while status bit 7 is set cause no array write and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle pulse that enters the programming phase while ready |
| wr_valid | input | 1 | Host word valid |
| wr_ready | output | 1 | Always high; a word is taken whenever `wr_valid` is high |
| wr_addr | input | 23 | Host word address; bits [22:16] select the block |
| wr_data | input | 16 | Host data word |
| arr_we | output | 1 | Array word commit strobe |
| arr_addr | output | 23 | Array word address for the commit |
| arr_data | output | 16 | Array data for the commit |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 0 transfer busy; other bits zero |

## Verification
The bench checks that the array pointer carries over between buffers. It sends the second fill to host offset zero, so a design that reloaded the pointer from the host address would write over the first buffer. It times the busy window to the exact cycle and the spacing of each commit, which catches a pacing counter off by one in either direction.

During each transfer it sends both a same-block word and an out-of-block word. A design that stored words while busy would corrupt the next buffer, and one that left the mode while busy would refuse the next fill.

It sends an unaligned first address, both at the start of a mode and after a good buffer. It also breaks off a partial fill with an out-of-block word. A design that programmed the partial buffer, or that skipped the alignment test on later fills, would produce array writes that nothing expects.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } bfp_state_e;

  localparam int STAT_W      = 8;
  localparam int STAT_BUSY   = 0;
  localparam int STAT_ERR    = 4;
  localparam int STAT_READY  = 7;
endpackage

// File: rtl/bfp_wbuf.sv
module bfp_wbuf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/bfp_prog_engine.sv
module bfp_prog_engine #(
  parameter int AW    = 23,
  parameter int DEPTH = 32,
  parameter int PACE  = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = (PACE > 1) ? $clog2(PACE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_val,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [IW-1:0] rd_idx,
  output logic          done
);
  logic          active_q;
  logic [PW-1:0] div_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] ptr_q;

  assign arr_we   = active_q && (div_q == PW'(PACE - 1));
  assign done     = arr_we && (idx_q == IW'(DEPTH - 1));
  assign arr_addr = ptr_q;
  assign rd_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      div_q    <= '0;
      idx_q    <= '0;
      ptr_q    <= '0;
    end else begin
      if (ptr_load) ptr_q <= ptr_val;
      if (start) begin
        active_q <= 1'b1;
        div_q    <= '0;
        idx_q    <= '0;
      end else if (active_q) begin
        if (arr_we) begin
          div_q <= '0;
          idx_q <= idx_q + IW'(1);
          ptr_q <= ptr_q + AW'(1);
          if (done) active_q <= 1'b0;
        end else begin
          div_q <= div_q + PW'(1);
        end
      end
    end
  end

  generate
    if (PACE > 1) begin : g_pace_chk
      assert_commit_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we)
        else $error("commit strobes back to back");
    end
  endgenerate

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !done) |=> (arr_addr == $past(arr_addr) + AW'(1)))
    else $error("array pointer did not advance by one");
endmodule

// File: rtl/bfp_wctl.sv
module bfp_wctl
  import bfp_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_LSB   = 16,
  parameter int PROG_CYC  = 4,
  localparam int IW       = $clog2(BUF_WORDS),
  localparam int BW       = AW - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              arr_we,
  output logic [AW-1:0]     arr_addr,
  output logic [DW-1:0]     arr_data,
  output logic [STAT_W-1:0] status
);
  bfp_state_e    state_q;
  logic [IW-1:0] cnt_q;
  logic [BW-1:0] blk_q;
  logic          blk_vld_q;
  logic          err_q;

  logic          take, in_blk, aligned, first_slot;
  logic          exit_req, abort_req, store, last_word, ptr_load;
  logic          eng_done;
  logic [IW-1:0] rd_idx;

  assign wr_ready   = 1'b1;
  assign take       = wr_valid && (state_q == ST_FILL);
  assign in_blk     = !blk_vld_q || (wr_addr[AW-1:BLK_LSB] == blk_q);
  assign aligned    = (wr_addr[IW-1:0] == '0);
  assign first_slot = (cnt_q == '0);
  assign exit_req   = take && !in_blk;
  assign abort_req  = take && in_blk && first_slot && !aligned;
  assign store      = take && in_blk && !(first_slot && !aligned);
  assign last_word  = store && (cnt_q == IW'(BUF_WORDS - 1));
  assign ptr_load   = store && !blk_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      blk_q     <= '0;
      blk_vld_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arm) begin
            state_q   <= ST_FILL;
            err_q     <= 1'b0;
            cnt_q     <= '0;
            blk_vld_q <= 1'b0;
          end
        end
        ST_FILL: begin
          if (exit_req) begin
            state_q <= ST_IDLE;
          end else if (abort_req) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else if (store) begin
            blk_vld_q <= 1'b1;
            blk_q     <= wr_addr[AW-1:BLK_LSB];
            cnt_q     <= last_word ? '0 : cnt_q + IW'(1);
            if (last_word) state_q <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (eng_done) state_q <= ST_FILL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  bfp_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) u_wbuf (
    .clk   (clk),
    .we    (store),
    .waddr (cnt_q),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (arr_data)
  );

  bfp_prog_engine #(.AW(AW), .DEPTH(BUF_WORDS), .PACE(PROG_CYC)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (last_word),
    .ptr_load (ptr_load),
    .ptr_val  (wr_addr),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .rd_idx   (rd_idx),
    .done     (eng_done)
  );

  always_comb begin
    status             = '0;
    status[STAT_READY] = (state_q == ST_IDLE);
    status[STAT_ERR]   = err_q;
    status[STAT_BUSY]  = (state_q == ST_PROG);
  end

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && !eng_done) |=> (state_q == ST_PROG))
    else $error("busy dropped before last commit");

  assert_refill_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (state_q == ST_FILL && cnt_q == '0))
    else $error("next fill does not start at slot 0");

  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG) |=> ($stable(blk_q) && $stable(err_q) && $stable(blk_vld_q)))
    else $error("state disturbed during transfer");

  assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (state_q == ST_IDLE))
    else $error("error raised without leaving the mode");
endmodule

// File: tb/bfp_wctl_tb.sv
module bfp_wctl_tb;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int NV = 4;

  localparam logic [AW-1:0] T_HOST [NV] = '{23'h070040, 23'h070000, 23'h07FFE0, 23'h070100};
  localparam logic [DW-1:0] T_SEED [NV] = '{16'h1000, 16'hA5A5, 16'hFFFF, 16'h0001};
  localparam logic [DW-1:0] T_STEP [NV] = '{16'h0001, 16'h0101, 16'hFFFF, 16'h0002};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [7:0]    status;

  int      n_cmp = 0;
  int      n_bad = 0;
  longint  cyc = 0;
  longint  fill_acc = 0;
  longint  last_we = 0;
  int      burst_pos = 0;
  logic [AW-1:0]    exp_ptr = '0;
  logic [AW+DW-1:0] exp_q [$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bfp_wctl u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // array-port monitor: order, data, address (R3, R4) and pacing (R3)
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R7/R10 unexpected array write", {arr_addr, arr_data}, 64'h0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_data} == e, "R3/R4 commit addr+data", {arr_addr, arr_data}, e);
        if (burst_pos == 0)
          chk(cyc - fill_acc == 3, "R3 first commit delay", cyc - fill_acc, 3);
        else
          chk(cyc - last_we == 4, "R3 commit spacing", cyc - last_we, 4);
        last_we   = cyc;
        burst_pos = (burst_pos + 1) % 32;
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic fill(input logic [AW-1:0] host, input logic [DW-1:0] seed, input logic [DW-1:0] step);
    for (int k = 0; k < 32; k++) begin
      logic [DW-1:0] d;
      d = seed + DW'(k) * step;
      exp_q.push_back({exp_ptr, d});
      exp_ptr = exp_ptr + AW'(1);
      wr(host + AW'(k), d);
    end
    fill_acc = cyc;
  endtask

  task automatic wait_to(input longint t);
    while (cyc != t) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h80, "R1 reset status", status, 8'h80);
    chk(arr_we == 1'b0, "R1 reset arr_we", arr_we, 0);
    chk(wr_ready == 1'b1, "R10 ready high", wr_ready, 1);

    // R10: writes while ready are ignored
    wr(23'h070000, 16'h1234);
    repeat (8) @(negedge clk);
    chk(status == 8'h80, "R10 idle write ignored", status, 8'h80);

    pulse_arm();
    chk(status == 8'h00, "R1 armed status", status, 8'h00);

    // vector table: consecutive fills in one mode
    exp_ptr = T_HOST[0];
    for (int v = 0; v < NV; v++) begin
      fill(T_HOST[v], T_SEED[v], T_STEP[v]);
      chk(status == 8'h01, "R2 busy after 32nd word", status, 8'h01);
      wr(T_HOST[v], 16'hDEAD);           // R6 same-block while busy
      wr(23'h090000, 16'hFFFF);          // R6 other-block while busy
      chk(status == 8'h01, "R6 busy write ignored", status, 8'h01);
      wait_to(fill_acc + 127);
      chk(status == 8'h01, "R5 busy at cycle 127", status, 8'h01);
      @(negedge clk);
      chk(status == 8'h00, "R5 busy cleared at 128", status, 8'h00);
    end
    chk(exp_q.size() == 0, "R3 all buffers committed", exp_q.size(), 0);

    // R8: exit between fills
    wr(23'h080000, 16'hFFFF);
    chk(status == 8'h80, "R8 exit status", status, 8'h80);

    // R7: unaligned first word of mode
    pulse_arm();
    chk(status == 8'h00, "R1 re-arm status", status, 8'h00);
    wr(23'h070043, 16'h0001);
    chk(status == 8'h90, "R7 unaligned abort", status, 8'h90);
    repeat (10) @(negedge clk);

    // R9: partial fill dropped on block change
    pulse_arm();
    chk(status == 8'h00, "R1 error cleared by arm", status, 8'h00);
    for (int k = 0; k < 10; k++) wr(23'h070000 + AW'(k), 16'h5000 + DW'(k));
    chk(status == 8'h00, "R9 partial fill pending", status, 8'h00);
    wr(23'h120000, 16'hFFFF);
    chk(status == 8'h80, "R9 partial exit status", status, 8'h80);
    repeat (140) @(negedge clk);
    chk(exp_q.size() == 0, "R9 nothing programmed", exp_q.size(), 0);

    // R4: pointer restarts on new mode; R7 unaligned second fill
    pulse_arm();
    exp_ptr = 23'h030020;
    fill(23'h030020, 16'h7700, 16'h0003);
    wait_to(fill_acc + 128);
    chk(status == 8'h00, "R5 second mode transfer done", status, 8'h00);
    chk(exp_q.size() == 0, "R4 restarted pointer buffer done", exp_q.size(), 0);
    wr(23'h030005, 16'h0042);
    chk(status == 8'h90, "R7 unaligned later fill abort", status, 8'h90);
    repeat (140) @(negedge clk);
    chk(arr_we == 1'b0, "R7 no write after abort", arr_we, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule